// File: doc/BRIEF.md
# Register List Stack Frame Sequencer

This block runs the two halves of a subroutine frame. On entry (the prologue) it saves a chosen subset of twelve callee-saved registers, r20 to r31, to the stack, then reserves room for locals. On exit (the epilogue) it releases that room, restores the same registers and can request a jump through a register. A single start strobe launches either operation. After that the block runs alone until it reports completion with the final stack pointer.

The block uses one word-wide memory port, which moves one 4-byte word per accepted request. It also drives one read port and one write port toward an external register file. Registers that are not selected cost no cycles. A request is held steady until the memory accepts it. Instruction decode and the register file itself sit outside the block.

Top module: `stack_frame_seq`

## Requirements
- R1: Mask bit i (i = 0..11) selects register r(20+i). During a save, the word written is the value the register file returns for that register.
- R2: In a prologue, the selected registers are written (memWe = 1) in ascending register order. The k-th write (k from 0) goes to address spIn - 4*(k+1), so lower-numbered registers land at higher addresses.
- R3: A prologue finishes with spOut = spIn - 4*N - 4*frameSize, where N is the number of mask bits set.
- R4: An epilogue first moves the stack pointer up by 4*frameSize. It then reads (memWe = 0) the selected registers in descending register order, the k-th read at spIn + 4*frameSize + 4*k. Each accepted read writes memRdData into that register through the write port.
- R5: An epilogue finishes with spOut = spIn + 4*frameSize + 4*N.
- R6: If an epilogue has a nonzero jumpIdx, jumpReq is high in the done cycle and jumpTarget holds the current value of register jumpIdx, read after all restores. With a jumpIdx of 0, or in a prologue, jumpReq stays low.
- R7: While memReq is high and memReady is low, the address and the direction stay unchanged and no register is written. The block moves on only when a request is accepted.
- R8: With memReady held high, done rises in the (N+1)-th cycle after the edge that samples start.
- R9: An empty mask with a frame size of 0 completes in the first cycle after start, with spOut = spIn.
- R10: A start received while busy and not in the done cycle has no effect on the operation in progress.
- R11: After reset, and again in the cycle after the done cycle, busy, done, memReq and jumpReq are low. done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled while idle |
| opEpilogue | input | 1 | 0 = prologue (save), 1 = epilogue (restore) |
| regMask | input | 12 | Bit i selects r(20+i) |
| frameSize | input | 5 | Local frame size in words |
| jumpIdx | input | 5 | Register holding the jump target; 0 = no jump |
| spIn | input | 32 | Stack pointer at start |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word address in bytes |
| memWrData | output | 32 | Write data |
| memRdData | input | 32 | Read data for the current address |
| memReady | input | 1 | Memory accepts the request this cycle |
| rfRdIdx | output | 5 | Register file read index |
| rfRdData | input | 32 | Register file read data, same cycle |
| rfWrEn | output | 1 | Register file write enable |
| rfWrIdx | output | 5 | Register file write index |
| rfWrData | output | 32 | Register file write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | 32 | Final stack pointer, valid with done |
| jumpReq | output | 1 | Jump requested, valid with done |
| jumpTarget | output | 32 | Jump target, valid with jumpReq |

## Verification
The assertions assume the register file returns data in the same cycle, and that nothing except this block writes the register file while it is busy. Under those assumptions the write data and the jump target are fixed by the block's own state. The bench models the register file and a small memory, and only this block writes to either. Stack pointers are chosen so that every frame stays inside the modelled memory. memReady comes either held high or from a pseudo-random sequence, so stalls of varied length occur while a request is pending.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef struct packed {
    logic run;     // operation in progress
    logic load;    // capture operands
    logic step;    // current transfer accepted
    logic finish;  // final cycle, no transfers left
  } seqStrobe_t;
endpackage

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       remEmpty,
  input  logic       memReady,
  output seqStrobe_t strb
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  always_comb begin
    strb.run    = (state == S_RUN);
    strb.load   = (state == S_IDLE) && start;
    strb.finish = (state == S_RUN) && remEmpty;
    strb.step   = (state == S_RUN) && !remEmpty && memReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            state <= S_IDLE;
    else if (strb.load)   state <= S_RUN;
    else if (strb.finish) state <= S_IDLE;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !strb.finish && !strb.run); // R11
endmodule

// File: rtl/sfs_dpath.sv
module sfs_dpath
  import sfs_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int REG_BASE = 20,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5,
  parameter int FRAME_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strb,
  input  logic                opEpilogue,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [FRAME_W-1:0]  frameSize,
  input  logic [IDX_W-1:0]    jumpIdx,
  input  logic [DATA_W-1:0]   spIn,
  input  logic                memReady,
  input  logic [DATA_W-1:0]   memRdData,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                remEmpty,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [IDX_W-1:0]    rfRdIdx,
  output logic                rfWrEn,
  output logic [IDX_W-1:0]    rfWrIdx,
  output logic [DATA_W-1:0]   rfWrData,
  output logic                done,
  output logic [DATA_W-1:0]   spOut,
  output logic                jumpReq,
  output logic [DATA_W-1:0]   jumpTarget
);
  localparam int BIT_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);

  logic                epiLat;
  logic [FRAME_W-1:0]  frameLat;
  logic [IDX_W-1:0]    jumpLat;
  logic [DATA_W-1:0]   spWork;
  logic [NUM_REGS-1:0] remMask;
  logic [BIT_W-1:0]    curBit;
  logic [IDX_W-1:0]    curReg;
  logic [DATA_W-1:0]   frameBytes;

  // mask bit to register mapping: fixed offset from REG_BASE
  function automatic logic [IDX_W-1:0] bitToReg(input logic [BIT_W-1:0] b);
    return IDX_W'(REG_BASE) + IDX_W'(b);
  endfunction

  // pick next register: lowest bit on save, highest bit on restore
  always_comb begin
    curBit = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (epiLat) begin
        if (remMask[i]) curBit = BIT_W'(i);
      end else begin
        if (remMask[NUM_REGS-1-i]) curBit = BIT_W'(NUM_REGS-1-i);
      end
    end
  end

  assign curReg     = bitToReg(curBit);
  assign frameBytes = DATA_W'({frameLat, 2'b00});
  assign remEmpty   = (remMask == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epiLat   <= 1'b0;
      frameLat <= '0;
      jumpLat  <= '0;
      spWork   <= '0;
      remMask  <= '0;
    end else if (strb.load) begin
      epiLat   <= opEpilogue;
      frameLat <= frameSize;
      jumpLat  <= jumpIdx;
      remMask  <= regMask;
      spWork   <= opEpilogue ? spIn + DATA_W'({frameSize, 2'b00}) : spIn;
    end else if (strb.step) begin
      remMask[curBit] <= 1'b0;
      spWork <= epiLat ? spWork + WORD_BYTES : spWork - WORD_BYTES;
    end
  end

  assign memReq     = strb.run && !remEmpty;
  assign memWe      = memReq && !epiLat;
  assign memAddr    = epiLat ? spWork : spWork - WORD_BYTES;
  assign memWrData  = rfRdData;
  assign rfRdIdx    = strb.finish ? jumpLat : curReg;
  assign rfWrEn     = strb.step && epiLat;
  assign rfWrIdx    = curReg;
  assign rfWrData   = memRdData;
  assign done       = strb.finish;
  assign spOut      = epiLat ? spWork : spWork - frameBytes;
  assign jumpReq    = strb.finish && epiLat && (jumpLat != '0);
  assign jumpTarget = rfRdData;

  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe)); // R7
  AST_NO_WRITE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |-> !rfWrEn); // R7
  AST_ASCEND_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !epiLat |=> !memReq || (curBit > $past(curBit))); // R2
  AST_DESCEND_POP: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && epiLat |=> !memReq || (curBit < $past(curBit))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    strb.run && !strb.finish |=> $countones(remMask) <= $countones($past(remMask))); // R10
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int REG_BASE = 20,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5,
  parameter int FRAME_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                opEpilogue,
  input  logic [NUM_REGS-1:0] regMask,
  input  logic [FRAME_W-1:0]  frameSize,
  input  logic [IDX_W-1:0]    jumpIdx,
  input  logic [DATA_W-1:0]   spIn,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  input  logic [DATA_W-1:0]   memRdData,
  input  logic                memReady,
  output logic [IDX_W-1:0]    rfRdIdx,
  input  logic [DATA_W-1:0]   rfRdData,
  output logic                rfWrEn,
  output logic [IDX_W-1:0]    rfWrIdx,
  output logic [DATA_W-1:0]   rfWrData,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   spOut,
  output logic                jumpReq,
  output logic [DATA_W-1:0]   jumpTarget
);
  seqStrobe_t strb;
  logic       remEmpty;

  sfs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .remEmpty(remEmpty), .memReady(memReady), .strb(strb)
  );

  sfs_dpath #(
    .NUM_REGS(NUM_REGS), .REG_BASE(REG_BASE), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .FRAME_W(FRAME_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .opEpilogue(opEpilogue), .regMask(regMask), .frameSize(frameSize),
    .jumpIdx(jumpIdx), .spIn(spIn), .memReady(memReady),
    .memRdData(memRdData), .rfRdData(rfRdData), .remEmpty(remEmpty),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .done(done), .spOut(spOut), .jumpReq(jumpReq), .jumpTarget(jumpTarget)
  );

  assign busy = strb.run;
endmodule

// File: tb/stack_frame_seq_tb.sv
module stack_frame_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, start, opEpilogue, memReady;
  logic [11:0] regMask;
  logic [4:0]  frameSize, jumpIdx;
  logic [31:0] spIn;
  logic        memReq, memWe, rfWrEn, busy, done, jumpReq;
  logic [31:0] memAddr, memWrData, memRdData, rfRdData, rfWrData, spOut, jumpTarget;
  logic [4:0]  rfRdIdx, rfWrIdx;

  logic [31:0] rf  [32];
  logic [31:0] mem [256];
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0, errors = 0, cycleCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_frame_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opEpilogue(opEpilogue),
    .regMask(regMask), .frameSize(frameSize), .jumpIdx(jumpIdx), .spIn(spIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memReady(memReady), .rfRdIdx(rfRdIdx),
    .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .busy(busy), .done(done), .spOut(spOut), .jumpReq(jumpReq), .jumpTarget(jumpTarget)
  );

  assign rfRdData  = rf[rfRdIdx];
  assign memRdData = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (rfWrEn) rf[rfWrIdx] <= rfWrData;
    if (memReq && memReady && memWe) mem[memAddr[9:2]] <= memWrData;
    cycleCount <= cycleCount + 1;
    if (cycleCount > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog R11: actual %0d cycles expected under 190000", cycleCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] salt);
    for (int r = 0; r < 32; r++) rf[r] = 32'hC000_0000 ^ (r * 32'h0101_0101) ^ salt;
    for (int a = 0; a < 256; a++) mem[a] = 32'h7000_0000 + a * 32'h0001_0003 + salt;
  endtask

  task automatic runOp(input bit epi, input logic [11:0] m, input logic [4:0] fr,
                       input logic [4:0] ji, input logic [31:0] sp, input bit stall, input bit poke);
    int order[12];
    int n = 0;
    int j = 0;
    int cyc = 0;
    bit doneSeen = 0;
    logic [31:0] base, expAddr, expSp;
    logic [31:0] expRf [32];
    preload({20'h0, m} ^ {27'h0, fr});
    for (int r = 0; r < 32; r++) expRf[r] = rf[r];
    if (!epi) begin
      for (int i = 0; i < 12; i++) if (m[i]) begin order[n] = i; n++; end
    end else begin
      for (int i = 11; i >= 0; i--) if (m[i]) begin order[n] = i; n++; end
    end
    base  = epi ? sp + 4 * fr : sp;
    expSp = epi ? sp + 4 * fr + 4 * n : sp - 4 * n - 4 * fr;
    @(negedge clk);
    opEpilogue = epi; regMask = m; frameSize = fr; jumpIdx = ji; spIn = sp; start = 1'b1;
    while (!doneSeen && cyc < 400) begin
      @(negedge clk);
      start = 1'b0;
      opEpilogue = epi; regMask = m; spIn = sp;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      memReady = stall ? (lfsr[0] | lfsr[1]) : 1'b1;
      #1;
      cyc++;
      if (done) begin
        doneSeen = 1;
        chk(epi ? "R5" : "R3", "final sp", spOut, expSp);
        if (n == 0 && fr == 0) chk("R9", "empty frame sp", spOut, sp);
        chk("R6", "jump request", {31'h0, jumpReq}, {31'h0, epi && ji != 0});
        if (epi && ji != 0) chk("R6", "jump target", jumpTarget, expRf[ji]);
        if (!stall) chk("R8", "done cycle", cyc, n + 1);
        chk(epi ? "R4" : "R2", "transfer count", j, n);
      end else if (memReq) begin
        if (j >= n) begin
          chk(epi ? "R4" : "R2", "extra transfer", j, n);
        end else begin
          expAddr = epi ? base + 4 * j : sp - 4 * (j + 1);
          chk(epi ? "R4" : "R2", "address", memAddr, expAddr);
          chk(epi ? "R4" : "R2", "direction", {31'h0, memWe}, {31'h0, !epi});
          if (!epi) chk("R1", "save data", memWrData, rf[20 + order[j]]);
          if (memReady) begin
            if (epi) begin
              chk("R4", "restore enable", {31'h0, rfWrEn}, 32'h1);
              chk("R1", "restore index", {27'h0, rfWrIdx}, 20 + order[j]);
              chk("R4", "restore data", rfWrData, mem[expAddr[9:2]]);
              expRf[20 + order[j]] = mem[expAddr[9:2]];
            end
            j++;
          end else begin
            chk("R7", "no write while stalled", {31'h0, rfWrEn}, 32'h0);
          end
        end
        if (poke && cyc == 1) begin
          // R10: a start pulse with other operands while busy
          start = 1'b1; opEpilogue = !epi; regMask = ~m; spIn = 32'h0000_0380;
        end
      end
    end
    if (!doneSeen) chk("R11", "done seen", 32'h0, 32'h1);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R11", "done one cycle", {30'h0, done, busy}, 32'h0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; opEpilogue = 1'b0; regMask = '0; frameSize = '0;
    jumpIdx = '0; spIn = '0; memReady = 1'b0;
    preload(32'h0);
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "reset outputs", {28'h0, busy, done, memReq, jumpReq}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R9: empty mask, zero frame, both operations
    runOp(1'b0, 12'h000, 5'd0, 5'd0, 32'h0000_0300, 1'b0, 1'b0);
    runOp(1'b1, 12'h000, 5'd0, 5'd25, 32'h0000_0100, 1'b0, 1'b0);
    // R2/R3 exhaustive masks for the prologue
    for (int m = 0; m < 4096; m++)
      runOp(1'b0, 12'(m), 5'(m ^ (m >> 7)), 5'(m >> 5), 32'h0000_0300, 1'b0, 1'b0);
    // R4/R5/R6 exhaustive masks for the epilogue
    for (int m = 0; m < 4096; m++)
      runOp(1'b1, 12'(m), 5'(m ^ (m >> 7)), 5'((m >> 3) ^ 19), 32'h0000_0100, 1'b0, 1'b0);
    // R7/R10: stalled memory and start pulses while busy
    for (int m = 0; m < 4096; m += 23) begin
      runOp(1'b0, 12'(m), 5'(m), 5'(m >> 4), 32'h0000_0300, 1'b1, 1'b1);
      runOp(1'b1, 12'(m), 5'(m >> 2), 5'(m >> 7), 32'h0000_0100, 1'b1, 1'b1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule